// File: doc/BRIEF.md
# Ethernet Frame Error Monitor

This block sits beside a receive and transmit path and turns low-level fault conditions into a small set of sticky error flags. On the receive side it takes a bit-serial stream, delimited by start-of-frame and end-of-frame strobes. It runs a CRC-32 shift register over every bit, including the frame check sequence. It tracks the bit position within the current byte and remembers whether any bit arrived while the receive FIFO was full. When the frame ends, it reports exactly one of three results: FIFO overflow, misalignment, or a bad checksum. A start of frame that finds no receive buffer is recorded as a missed frame, and the rest of that frame is ignored.

On the transmit side it counts the data bytes of each frame. It flags a transmitter that keeps sending past the maximum frame length. It also flags a byte request that finds the transmit FIFO empty. A third unit times each memory request and flags one that no acknowledge answers in time.

All seven conditions land in one error register. Each bit stays set until software writes a 1 to it. A single interrupt output is high while any bit is set.

Top module: `efm_top`

## Requirements
- R1: While rst is high at a clock edge, err_flags becomes 0 and irq is low after that edge.
- R2: The CRC register is preset to all ones at rx_sof and advanced with polynomial 0x04C11DB7 for each received bit, in wire order. At rx_eof of a frame with a whole number of bytes and no overflow, err_flags[0] is set if the register differs from 0xC704DD7B. A frame that ends with a correct check sequence sets no flag.
- R3: At rx_eof, if the received bit count is not a multiple of 8 and there was no overflow, err_flags[1] is set and err_flags[0] is not.
- R4: If a bit arrives with rx_fifo_full high during an accepted frame, err_flags[2] is set at that frame's rx_eof and not before. Bit 0 and bit 1 are not set for that frame.
- R5: A tx_byte strobe inside a transmit frame with tx_fifo_empty high sets err_flags[3] at that edge.
- R6: An rx_sof with rx_buf_rdy low sets err_flags[4]. The bits and rx_eof of that frame then set no other flag.
- R7: Within one transmit frame, the tx_byte strobe that takes the count past MAX_TX_BYTES (default 1518) sets err_flags[5]. Exactly MAX_TX_BYTES strobes set nothing.
- R8: If mem_ack is not seen at any of the TMO_CYCLES (default 256) edges after the most recent mem_req, err_flags[6] is set at the last of those edges. An acknowledge at the final edge is in time. A new mem_req restarts the window.
- R9: A set flag stays set until clr_wr is high with a 1 in its clr_mask position. A new event for a bit in the same cycle as its clear leaves that bit set.
- R10: irq is high exactly when err_flags is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | Receive frame start strobe |
| rx_eof | input | 1 | Receive frame end strobe |
| rx_bit_vld | input | 1 | A receive bit is present on rx_bit |
| rx_bit | input | 1 | Receive data bit, wire order |
| rx_buf_rdy | input | 1 | A receive buffer is available at rx_sof |
| rx_fifo_full | input | 1 | Receive FIFO cannot accept the current bit |
| tx_sof | input | 1 | Transmit frame start strobe |
| tx_eof | input | 1 | Transmit frame end strobe |
| tx_byte | input | 1 | Transmitter takes one data byte |
| tx_fifo_empty | input | 1 | Transmit FIFO has no byte to give |
| mem_req | input | 1 | Memory request issued (restarts the timer) |
| mem_ack | input | 1 | Memory acknowledge |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 7 | Bits of err_flags to clear |
| err_flags | output | 7 | Sticky errors: 0 CRC, 1 align, 2 overflow, 3 underflow, 4 missed, 5 babble, 6 memory timeout |
| irq | output | 1 | High while any error flag is set |

## Verification
Every flag becomes visible just after the clock edge that samples its cause. For the frame checks, that cause is the rx_eof edge. For babble it is the offending byte strobe. For the timeout it is the TMO_CYCLES-th edge after the request. The bench changes inputs only just after a falling edge and reads outputs at the next falling edge, so each read sees exactly one rising edge's effect. The overflow case is read once before the end strobe and once after it. The timeout cases place the acknowledge at a counted edge, including the last edge in time and the first edge too late.

// File: rtl/efm_pkg.sv
package efm_pkg;

    localparam int ERR_W = 7;

    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

    // Field order makes bit 0 the checksum error and bit 6 the memory timeout.
    typedef struct packed {
        logic mtmo;
        logic babl;
        logic miss;
        logic unfl;
        logic ovfl;
        logic align;
        logic crc;
    } err_evt_t;

    // One serial step of the frame checksum, data taken in wire order.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        return {c[30:0], 1'b0} ^ ((c[31] ^ b) ? CRC_POLY : 32'h0);
    endfunction

endpackage

// File: rtl/efm_rx_check.sv
module efm_rx_check
    import efm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sof,
    input  logic eof,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic buf_rdy,
    input  logic fifo_full,
    output logic evt_crc,
    output logic evt_align,
    output logic evt_ovfl,
    output logic evt_miss
);
    localparam int PH_W = 3;

    logic            active;
    logic [31:0]     crc_q;
    logic [PH_W-1:0] phase;
    logic            ovfl_pend;
    logic            ending;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            crc_q     <= '1;
            phase     <= '0;
            ovfl_pend <= 1'b0;
        end else if (sof) begin
            active    <= buf_rdy;
            crc_q     <= '1;
            phase     <= '0;
            ovfl_pend <= 1'b0;
        end else if (active) begin
            if (eof) begin
                active <= 1'b0;
            end else if (bit_vld) begin
                crc_q <= crc_step(crc_q, bit_in);
                phase <= phase + PH_W'(1);
                if (fifo_full) ovfl_pend <= 1'b1;
            end
        end
    end

    always_comb begin
        ending    = active && eof && !sof;
        evt_ovfl  = ending && ovfl_pend;
        evt_align = ending && !ovfl_pend && (phase != '0);
        evt_crc   = ending && !ovfl_pend && (phase == '0) && (crc_q != CRC_RESIDUE);
        evt_miss  = sof && !buf_rdy;
    end

endmodule

// File: rtl/efm_tx_watch.sv
module efm_tx_watch #(
    parameter int MAX_BYTES = 1518
) (
    input  logic clk,
    input  logic rst,
    input  logic sof,
    input  logic eof,
    input  logic byte_stb,
    input  logic fifo_empty,
    output logic evt_babl,
    output logic evt_unfl
);
    localparam int CW = $clog2(MAX_BYTES + 2);

    logic          active;
    logic [CW-1:0] cnt;
    logic          take;

    assign take = active && byte_stb && !sof;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (sof) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && eof) begin
            active <= 1'b0;
        end else if (take && cnt != CW'(MAX_BYTES + 1)) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign evt_babl = take && (cnt == CW'(MAX_BYTES));
    assign evt_unfl = take && fifo_empty;

endmodule

// File: rtl/efm_mem_timer.sv
module efm_mem_timer #(
    parameter int TMO_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic ack,
    output logic evt_tmo
);
    localparam int CW = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

    logic          pend;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (req) begin
            pend <= 1'b1;
            cnt  <= '0;
        end else if (pend) begin
            if (ack || cnt == LAST) pend <= 1'b0;
            else                    cnt  <= cnt + CW'(1);
        end
    end

    assign evt_tmo = pend && !req && !ack && (cnt == LAST);

endmodule

// File: rtl/efm_err_reg.sv
module efm_err_reg
    import efm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  err_evt_t         evt,
    input  logic             clr_wr,
    input  logic [ERR_W-1:0] clr_mask,
    output logic [ERR_W-1:0] flags
);
    logic [ERR_W-1:0] kill;

    assign kill = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~kill) | evt;
    end

endmodule

// File: rtl/efm_top.sv
module efm_top
    import efm_pkg::*;
#(
    parameter int MAX_TX_BYTES = 1518,
    parameter int TMO_CYCLES   = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_bit_vld,
    input  logic             rx_bit,
    input  logic             rx_buf_rdy,
    input  logic             rx_fifo_full,
    input  logic             tx_sof,
    input  logic             tx_eof,
    input  logic             tx_byte,
    input  logic             tx_fifo_empty,
    input  logic             mem_req,
    input  logic             mem_ack,
    input  logic             clr_wr,
    input  logic [ERR_W-1:0] clr_mask,
    output logic [ERR_W-1:0] err_flags,
    output logic             irq
);
    err_evt_t         evt;
    logic [ERR_W-1:0] evt_vec;

    efm_rx_check u_rx (
        .clk       (clk),
        .rst       (rst),
        .sof       (rx_sof),
        .eof       (rx_eof),
        .bit_vld   (rx_bit_vld),
        .bit_in    (rx_bit),
        .buf_rdy   (rx_buf_rdy),
        .fifo_full (rx_fifo_full),
        .evt_crc   (evt.crc),
        .evt_align (evt.align),
        .evt_ovfl  (evt.ovfl),
        .evt_miss  (evt.miss)
    );

    efm_tx_watch #(.MAX_BYTES(MAX_TX_BYTES)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .sof        (tx_sof),
        .eof        (tx_eof),
        .byte_stb   (tx_byte),
        .fifo_empty (tx_fifo_empty),
        .evt_babl   (evt.babl),
        .evt_unfl   (evt.unfl)
    );

    efm_mem_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .req     (mem_req),
        .ack     (mem_ack),
        .evt_tmo (evt.mtmo)
    );

    efm_err_reg u_err (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_wr   (clr_wr),
        .clr_mask (clr_mask),
        .flags    (err_flags)
    );

    assign evt_vec = evt;
    assign irq     = |err_flags;

endmodule

// File: rtl/efm_checker.sv
module efm_checker
    import efm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rx_sof,
    input logic             rx_buf_rdy,
    input logic             mem_req,
    input logic             clr_wr,
    input logic [ERR_W-1:0] clr_mask,
    input logic [ERR_W-1:0] evt_vec,
    input logic [ERR_W-1:0] err_flags,
    input logic             irq
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (err_flags == '0 && !irq));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && evt_vec == '0) |=> ((err_flags & $past(clr_mask)) == '0));

    assert_irq_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (evt_vec != '0) |=> irq);

    assert_missed_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_sof && !rx_buf_rdy) |=> err_flags[4]);

    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !evt_vec[6]);

endmodule

bind efm_top efm_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .rx_sof     (rx_sof),
    .rx_buf_rdy (rx_buf_rdy),
    .mem_req    (mem_req),
    .clr_wr     (clr_wr),
    .clr_mask   (clr_mask),
    .evt_vec    (evt_vec),
    .err_flags  (err_flags),
    .irq        (irq)
);

// File: tb/efm_top_tb_top.sv
module efm_top_tb_top;
    import efm_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, rx_sof, rx_eof, rx_bit_vld, rx_bit, rx_buf_rdy, rx_fifo_full;
    logic tx_sof, tx_eof, tx_byte, tx_fifo_empty, mem_req, mem_ack, clr_wr;
    logic [ERR_W-1:0] clr_mask, err_flags;
    logic irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] fbuf [0:31];

    efm_top dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic quiet();
        rx_sof = 0; rx_eof = 0; rx_bit_vld = 0; rx_bit = 0; rx_buf_rdy = 1; rx_fifo_full = 0;
        tx_sof = 0; tx_eof = 0; tx_byte = 0; tx_fifo_empty = 0;
        mem_req = 0; mem_ack = 0; clr_wr = 0; clr_mask = '0;
    endtask

    task automatic clear_all(input string req);
        clr_wr = 1; clr_mask = '1; tick(); clr_wr = 0; clr_mask = '0;
        check(req, {err_flags, irq}, 0);
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = '1;
        for (int i = 0; i < n; i++) begin
            c ^= {24'h0, fbuf[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return c;
    endfunction

    // mode: 0 good, 1 corrupt, 2 misaligned, 3 overflow, 4 no buffer
    task automatic rx_frame(input int n, input int mode);
        logic [31:0] fcs;
        logic [6:0]  exp;
        int          extra;
        for (int i = 0; i < n; i++) fbuf[i] = 8'($urandom);
        fcs = ~ref_crc(n);
        for (int j = 0; j < 4; j++) fbuf[n + j] = fcs[8*j +: 8];
        if (mode == 1) fbuf[0][3] = ~fbuf[0][3];
        extra = (mode == 2) ? $urandom_range(1, 7) : 0;
        rx_sof = 1; rx_buf_rdy = (mode != 4); tick(); rx_sof = 0; rx_buf_rdy = 1;
        for (int i = 0; i < n + 4; i++) begin
            for (int b = 0; b < 8; b++) begin
                rx_bit_vld = 1; rx_bit = fbuf[i][b];
                rx_fifo_full = (mode == 3) && (i == 1) && (b == 3);
                tick();
            end
        end
        rx_fifo_full = 0;
        for (int e = 0; e < extra; e++) begin
            rx_bit_vld = 1; rx_bit = 1'($urandom); tick();
        end
        rx_bit_vld = 0;
        if (mode == 3) check("R4 overflow not before end", 32'(err_flags), 0);
        rx_eof = 1; tick(); rx_eof = 0;
        case (mode)
            1:       exp = 7'h01;
            2:       exp = 7'h02;
            3:       exp = 7'h04;
            4:       exp = 7'h10;
            default: exp = 7'h00;
        endcase
        case (mode)
            0: check("R2 good frame", 32'(err_flags), 32'(exp));
            1: check("R2 crc error", 32'(err_flags), 32'(exp));
            2: check("R3 align error", 32'(err_flags), 32'(exp));
            3: check("R4 overflow", 32'(err_flags), 32'(exp));
            default: check("R6 missed frame", 32'(err_flags), 32'(exp));
        endcase
        check("R10 irq", 32'(irq), 32'(exp != 0));
        clear_all("R9 clear after frame");
    endtask

    task automatic mem_try(input int d);
        mem_req = 1; tick(); mem_req = 0;
        for (int k = 1; k < d; k++) tick();
        mem_ack = 1; tick(); mem_ack = 0;
        check("R8 timeout", 32'(err_flags[6]), 32'(d > 256));
        clear_all("R9 clear after timeout");
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4417));
        quiet();
        rst = 1; tick(); tick();
        check("R1 reset flags", 32'(err_flags), 0);
        check("R1 reset irq", 32'(irq), 0);
        rst = 0; tick();

        for (int m = 0; m < 5; m++) rx_frame(4, m);
        rx_frame(1, 0);
        rx_frame(20, 2);
        for (int it = 0; it < 25; it++) rx_frame($urandom_range(1, 20), $urandom_range(0, 4));

        // R6: bad frame with no buffer reports only the miss
        rx_frame(6, 4);

        // R5 underflow, then R9 set-beats-clear in the same cycle
        tx_sof = 1; tick(); tx_sof = 0;
        tx_byte = 1; tx_fifo_empty = 1; tick();
        check("R5 underflow", 32'(err_flags), 32'h08);
        clr_wr = 1; clr_mask = 7'h08; tick();
        clr_wr = 0; clr_mask = '0; tx_byte = 0; tx_fifo_empty = 0;
        check("R9 set wins over clear", 32'(err_flags), 32'h08);
        tx_eof = 1; tick(); tx_eof = 0;
        rx_sof = 1; rx_buf_rdy = 0; tick(); rx_sof = 0; rx_buf_rdy = 1;
        clr_wr = 1; clr_mask = 7'h10; tick(); clr_wr = 0; clr_mask = '0;
        check("R9 partial clear", 32'(err_flags), 32'h08);
        check("R10 irq with one flag", 32'(irq), 1);
        clear_all("R9 full clear");

        // R7 babble limit
        tx_sof = 1; tick(); tx_sof = 0;
        for (int i = 0; i < 1518; i++) begin tx_byte = 1; tick(); end
        tx_byte = 0;
        check("R7 at limit", 32'(err_flags), 0);
        tx_byte = 1; tick(); tx_byte = 0;
        check("R7 babble", 32'(err_flags), 32'h20);
        tx_eof = 1; tick(); tx_eof = 0;
        clear_all("R9 clear after babble");

        // R8 timeout windows
        mem_try(1);
        mem_try(256);
        mem_try(257);
        for (int it = 0; it < 6; it++) mem_try($urandom_range(200, 300));
        mem_req = 1; tick(); mem_req = 0;
        for (int k = 0; k < 200; k++) tick();
        mem_req = 1; tick(); mem_req = 0;
        for (int k = 0; k < 199; k++) tick();
        mem_ack = 1; tick(); mem_ack = 0;
        check("R8 restart on new request", 32'(err_flags), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule